// File: doc/BRIEF.md
# Scaled Fixed-Point System Counter

This block is a free-running 64-bit timestamp source for the timers of a chip. Internally it keeps an 88-bit accumulator that holds a 64-bit integer count and a 24-bit binary fraction. Each cycle in which the tick input is high and the counter is enabled advances the accumulator. The step is either exactly one count, or a programmable increment in 8.24 fixed point, so a counter clocked at one rate can present timestamps at another. The integer part is driven out on `stamp_o` every cycle.

Software reaches the counter over a simple 32-bit memory-mapped bus. The bus carries a frame-select bit that picks one of two 4 KiB windows. The control window holds the mode bits, the scale value and both halves of a writable count. The status window is a read-only view of the count. Both windows end in a block of fixed identification bytes. A read is sampled on a clock edge and its data appears on `bus_rdata_o` after that edge. `bus_rdata_o` holds its value until the next read.

Top module: `sysctr_top`

## Requirements
- R1: After a synchronous reset, the following hold: the mode register reads 0, the scale register reads 0x01000000 (a step of 1.0), the count reads 0 and `stamp_o` is 0.
- R2: While the enable bit (mode bit 0) is 0, ticks do not change the count, whatever the other mode bits hold.
- R3: With enable set and scaling off (mode bit 2 clear), every cycle with `tick_i` high adds exactly one to the 64-bit count, with carry from the low half into the high half. Cycles without a tick leave the count unchanged.
- R4: With enable and scaling both set, every tick adds the 32-bit scale value to the 88-bit accumulator. The visible count is the accumulator's top 64 bits, so a scale of 0x00800000 advances the count by one every two ticks, and a scale of 0x03000000 advances it by three per tick. A new scale value takes effect from the next tick.
- R5: The mode register at control offset 0x000 stores bits 4:0 as written. Bits 31:5 read as zero and ignore writes.
- R6: In the control window, the following offsets have fixed behaviour. Offset 0x004 reads zero. Offsets 0x010 and 0x0D0 both reach the single scale register. Offset 0x0D4 reads zero and ignores writes. Offset 0x01C is a read-only identity word that reads 0x00020001.
- R7: A write to control offset 0x008 replaces count bits 31:0, and a write to 0x00C replaces count bits 63:32. The other half keeps its value, and the 24-bit fraction is cleared. The write takes effect whether or not the counter is enabled.
- R8: A tick in the same cycle as a count write is discarded, and the count takes exactly the written value.
- R9: The status window (`bus_frame_i` = 1) returns count bits 31:0 at 0x000 and bits 63:32 at 0x004. Writes to the status window change no state.
- R10: Both windows return identification bytes in bits 7:0 of the words at 0xFD0..0xFFC, in that address order: 04,00,00,00, then X,B0,0B,00, then 0D,F0,05,B1. X is 0xBA in the control window and 0xBB in the status window.
- R11: A read of any unmapped offset returns zero. Read data appears after the sampling edge and is held until the next read. Address bits 1:0 are ignored.
- R12: `stamp_o` always equals the current 64-bit integer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count tick, one per cycle when high |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_frame_i | input | 1 | 0 = control window, 1 = status window |
| bus_addr_i | input | 12 | Byte offset inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| stamp_o | output | 64 | Integer part of the count |

## Verification
A software write to one count half and a counter tick can land on the same clock edge, and the two compete for the accumulator. The bench raises `tick_i` during the exact cycle in which a write to the low count half is sampled, with the counter enabled and unscaled. It then expects `stamp_o` to equal the written value, not that value plus one. The bench also checks the fraction-clearing side of a count write. It leaves half a count pending under a 0.5 scale, rewrites the count, and confirms that the next single tick does not carry into the integer part.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;

  // Control-window byte offsets
  localparam int OFS_MODE     = 'h000;
  localparam int OFS_STATE    = 'h004;
  localparam int OFS_CNT_LO   = 'h008;
  localparam int OFS_CNT_HI   = 'h00C;
  localparam int OFS_SCALE_A  = 'h010;
  localparam int OFS_IDENT    = 'h01C;
  localparam int OFS_SCALE_B  = 'h0D0;
  localparam int OFS_SCALE_NU = 'h0D4;
  // Status-window byte offsets
  localparam int OFS_VIEW_LO  = 'h000;
  localparam int OFS_VIEW_HI  = 'h004;
  // Identification block (both windows)
  localparam int OFS_IDB_FIRST = 'hFD0;
  localparam int OFS_IDB_LAST  = 'hFFC;

  localparam int          MODE_BITS   = 5;
  localparam int          MODE_EN     = 0;
  localparam int          MODE_SCALE  = 2;
  localparam logic [31:0] SCALE_RESET = 32'h0100_0000;
  localparam logic [31:0] IDENT_WORD  = 32'h0002_0001;

  typedef enum logic {WIN_CTRL = 1'b0, WIN_VIEW = 1'b1} win_e;

  function automatic logic [7:0] ident_byte(input logic view_win, input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = view_win ? 8'hBB : 8'hBA;
      4'd5:    b = 8'hB0;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sysctr_decode.sv
module sysctr_decode import sysctr_pkg::*; #(
  parameter int WA_W = 10
) (
  input  logic            sel,
  input  logic            wr,
  input  logic            win,
  input  logic [WA_W-1:0] wa,
  output logic            wr_mode,
  output logic            wr_scale,
  output logic            wr_lo,
  output logic            wr_hi
);
  localparam logic [WA_W-1:0] W_MODE = WA_W'(OFS_MODE >> 2);
  localparam logic [WA_W-1:0] W_LO   = WA_W'(OFS_CNT_LO >> 2);
  localparam logic [WA_W-1:0] W_HI   = WA_W'(OFS_CNT_HI >> 2);
  localparam logic [WA_W-1:0] W_SCA  = WA_W'(OFS_SCALE_A >> 2);
  localparam logic [WA_W-1:0] W_SCB  = WA_W'(OFS_SCALE_B >> 2);

  logic ctrl_wr;
  assign ctrl_wr  = sel && wr && (win == WIN_CTRL);
  assign wr_mode  = ctrl_wr && (wa == W_MODE);
  assign wr_scale = ctrl_wr && ((wa == W_SCA) || (wa == W_SCB));
  assign wr_lo    = ctrl_wr && (wa == W_LO);
  assign wr_hi    = ctrl_wr && (wa == W_HI);
endmodule

// File: rtl/sysctr_cfg.sv
module sysctr_cfg import sysctr_pkg::*; #(
  parameter int SCALE_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_mode,
  input  logic                 wr_scale,
  input  logic [MODE_BITS-1:0] mode_wdata,
  input  logic [SCALE_W-1:0]   scale_wdata,
  output logic [MODE_BITS-1:0] mode_q,
  output logic [SCALE_W-1:0]   scale_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      scale_q <= SCALE_W'(SCALE_RESET);
    end else begin
      if (wr_mode)  mode_q  <= mode_wdata;
      if (wr_scale) scale_q <= scale_wdata;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_mode |=> $stable(mode_q)); // R5
  AST_SCALE_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_scale |=> $stable(scale_q)); // R6
endmodule

// File: rtl/sysctr_accum.sv
module sysctr_accum #(
  parameter int INT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               scen,
  input  logic               tick,
  input  logic [SCALE_W-1:0] scale,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [INT_W/2-1:0] wdata,
  output logic [INT_W-1:0]   count_o
);
  localparam int ACC_W = INT_W + FRAC_W;
  localparam int HALF  = INT_W / 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [HALF-1:0]  new_hi, new_lo;
  logic             wr_any;

  assign wr_any = wr_lo || wr_hi;
  assign step   = scen ? {{(ACC_W-SCALE_W){1'b0}}, scale}
                       : {{(INT_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  assign new_hi = wr_hi ? wdata : acc_q[ACC_W-1 -: HALF];
  assign new_lo = wr_lo ? wdata : acc_q[FRAC_W +: HALF];

  always_ff @(posedge clk) begin
    if (rst)                acc_q <= '0;
    else if (wr_any)        acc_q <= {new_hi, new_lo, {FRAC_W{1'b0}}};
    else if (en && tick)    acc_q <= acc_q + step;
  end

  assign count_o = acc_q[ACC_W-1 -: INT_W];

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst) (!en && !wr_any) |=> $stable(count_o)); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst) (!tick && !wr_any) |=> $stable(acc_q)); // R3
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst) (en && !scen && tick && !wr_any) |=> count_o == $past(count_o) + 1'b1); // R3
  AST_SCALED_STEP: assert property (@(posedge clk) disable iff (rst) (en && scen && tick && !wr_any) |=> acc_q == $past(acc_q) + {{(ACC_W-SCALE_W){1'b0}}, $past(scale)}); // R4
  AST_WR_CLEARS_FRAC: assert property (@(posedge clk) disable iff (rst) wr_any |=> acc_q[FRAC_W-1:0] == '0); // R7
  AST_WR_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst) (wr_lo && !wr_hi) |=> count_o[INT_W-1:HALF] == $past(count_o[INT_W-1:HALF])); // R7
  AST_WR_BEATS_TICK: assert property (@(posedge clk) disable iff (rst) (wr_lo && tick) |=> count_o[HALF-1:0] == $past(wdata)); // R8
endmodule

// File: rtl/sysctr_rdport.sv
module sysctr_rdport import sysctr_pkg::*; #(
  parameter int WA_W    = 10,
  parameter int INT_W   = 64,
  parameter int SCALE_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 wr,
  input  logic                 win,
  input  logic [WA_W-1:0]      wa,
  input  logic [MODE_BITS-1:0] mode,
  input  logic [SCALE_W-1:0]   scale,
  input  logic [INT_W-1:0]     count,
  output logic [31:0]          rdata_q
);
  localparam int HALF = INT_W / 2;
  localparam logic [WA_W-1:0] W_MODE  = WA_W'(OFS_MODE >> 2);
  localparam logic [WA_W-1:0] W_STATE = WA_W'(OFS_STATE >> 2);
  localparam logic [WA_W-1:0] W_LO    = WA_W'(OFS_CNT_LO >> 2);
  localparam logic [WA_W-1:0] W_HI    = WA_W'(OFS_CNT_HI >> 2);
  localparam logic [WA_W-1:0] W_SCA   = WA_W'(OFS_SCALE_A >> 2);
  localparam logic [WA_W-1:0] W_ID    = WA_W'(OFS_IDENT >> 2);
  localparam logic [WA_W-1:0] W_SCB   = WA_W'(OFS_SCALE_B >> 2);
  localparam logic [WA_W-1:0] W_SCN   = WA_W'(OFS_SCALE_NU >> 2);
  localparam logic [WA_W-1:0] W_VLO   = WA_W'(OFS_VIEW_LO >> 2);
  localparam logic [WA_W-1:0] W_VHI   = WA_W'(OFS_VIEW_HI >> 2);
  localparam logic [WA_W-1:0] W_IDB0  = WA_W'(OFS_IDB_FIRST >> 2);
  localparam logic [WA_W-1:0] W_IDB1  = WA_W'(OFS_IDB_LAST >> 2);

  logic [31:0] ctrl_val, view_val, rd_val;
  logic        in_idb;
  logic [3:0]  idb_idx;

  assign in_idb  = (wa >= W_IDB0) && (wa <= W_IDB1);
  assign idb_idx = wa[3:0] - W_IDB0[3:0];

  always_comb begin
    ctrl_val = '0;
    if (in_idb) ctrl_val = {24'h0, ident_byte(1'b0, idb_idx)};
    else begin
      case (wa)
        W_MODE:       ctrl_val = 32'(mode);
        W_LO:         ctrl_val = 32'(count[HALF-1:0]);
        W_HI:         ctrl_val = 32'(count[INT_W-1:HALF]);
        W_SCA, W_SCB: ctrl_val = 32'(scale);
        W_ID:         ctrl_val = IDENT_WORD;
        W_STATE, W_SCN: ctrl_val = '0;
        default:      ctrl_val = '0;
      endcase
    end
  end

  always_comb begin
    view_val = '0;
    if (in_idb) view_val = {24'h0, ident_byte(1'b1, idb_idx)};
    else if (wa == W_VLO) view_val = 32'(count[HALF-1:0]);
    else if (wa == W_VHI) view_val = 32'(count[INT_W-1:HALF]);
  end

  assign rd_val = (win == WIN_VIEW) ? view_val : ctrl_val;

  always_ff @(posedge clk) begin
    if (rst)              rdata_q <= '0;
    else if (sel && !wr)  rdata_q <= rd_val;
  end

  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst) !(sel && !wr) |=> $stable(rdata_q)); // R11
  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (sel && !wr && win == WIN_CTRL && wa == W_MODE) |=> rdata_q[31:MODE_BITS] == '0); // R5
  AST_VIEW_LO_MATCH: assert property (@(posedge clk) disable iff (rst) (sel && !wr && win == WIN_VIEW && wa == W_VLO) |=> rdata_q == 32'($past(count[HALF-1:0]))); // R9
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top import sysctr_pkg::*; #(
  parameter int ADDR_W  = 12,
  parameter int INT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_frame_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [INT_W-1:0]  stamp_o
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]      wa;
  logic                 wr_mode, wr_scale, wr_lo, wr_hi;
  logic [MODE_BITS-1:0] mode_q;
  logic [SCALE_W-1:0]   scale_q;
  logic [INT_W-1:0]     count;

  assign wa = bus_addr_i[ADDR_W-1:2];

  sysctr_decode #(.WA_W(WA_W)) u_dec (
    .sel(bus_sel_i), .wr(bus_wr_i), .win(bus_frame_i), .wa(wa),
    .wr_mode(wr_mode), .wr_scale(wr_scale), .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  sysctr_cfg #(.SCALE_W(SCALE_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_scale(wr_scale),
    .mode_wdata(bus_wdata_i[MODE_BITS-1:0]), .scale_wdata(bus_wdata_i[SCALE_W-1:0]),
    .mode_q(mode_q), .scale_q(scale_q)
  );

  sysctr_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) u_acc (
    .clk(clk), .rst(rst), .en(mode_q[MODE_EN]), .scen(mode_q[MODE_SCALE]),
    .tick(tick_i), .scale(scale_q), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata_i[INT_W/2-1:0]), .count_o(count)
  );

  sysctr_rdport #(.WA_W(WA_W), .INT_W(INT_W), .SCALE_W(SCALE_W)) u_rd (
    .clk(clk), .rst(rst), .sel(bus_sel_i), .wr(bus_wr_i), .win(bus_frame_i),
    .wa(wa), .mode(mode_q), .scale(scale_q), .count(count), .rdata_q(bus_rdata_o)
  );

  assign stamp_o = count;

  AST_VIEW_WR_IGNORED: assert property (@(posedge clk) disable iff (rst) (bus_sel_i && bus_wr_i && bus_frame_i) |=> ($stable(mode_q) && $stable(scale_q))); // R9
  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (stamp_o == '0 && mode_q == '0)); // R1
endmodule

// File: tb/sysctr_tb.sv
module sysctr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_frame_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [63:0] stamp_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysctr_top dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_frame_i(bus_frame_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .stamp_o(stamp_o)
  );

  // {window, offset, expected} read right after reset
  localparam int NRD = 34;
  localparam logic [44:0] RD_TAB [NRD] = '{
    {1'b0, 12'h000, 32'h0000_0000}, // R1 mode
    {1'b0, 12'h010, 32'h0100_0000}, // R1 scale
    {1'b0, 12'h008, 32'h0000_0000}, // R1 count lo
    {1'b0, 12'h00C, 32'h0000_0000}, // R1 count hi
    {1'b0, 12'h004, 32'h0000_0000}, // R6
    {1'b0, 12'h0D0, 32'h0100_0000}, // R6 alias
    {1'b0, 12'h0D4, 32'h0000_0000}, // R6
    {1'b0, 12'h01C, 32'h0002_0001}, // R6 ident
    {1'b0, 12'h100, 32'h0000_0000}, // R11 unmapped
    {1'b1, 12'h008, 32'h0000_0000}, // R11 unmapped
    {1'b0, 12'hFD0, 32'h04}, {1'b0, 12'hFD4, 32'h00}, {1'b0, 12'hFD8, 32'h00}, {1'b0, 12'hFDC, 32'h00},
    {1'b0, 12'hFE0, 32'hBA}, {1'b0, 12'hFE4, 32'hB0}, {1'b0, 12'hFE8, 32'h0B}, {1'b0, 12'hFEC, 32'h00},
    {1'b0, 12'hFF0, 32'h0D}, {1'b0, 12'hFF4, 32'hF0}, {1'b0, 12'hFF8, 32'h05}, {1'b0, 12'hFFC, 32'hB1},
    {1'b1, 12'hFD0, 32'h04}, {1'b1, 12'hFD4, 32'h00}, {1'b1, 12'hFD8, 32'h00}, {1'b1, 12'hFDC, 32'h00},
    {1'b1, 12'hFE0, 32'hBB}, {1'b1, 12'hFE4, 32'hB0}, {1'b1, 12'hFE8, 32'h0B}, {1'b1, 12'hFEC, 32'h00},
    {1'b1, 12'hFF0, 32'h0D}, {1'b1, 12'hFF4, 32'hF0}, {1'b1, 12'hFF8, 32'h05}, {1'b1, 12'hFFC, 32'hB1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic win, input logic [11:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_frame_i = win; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic bus_read(input logic win, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_frame_i = win; bus_addr_i = a;
    @(negedge clk);
    bus_sel_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 stamp after reset", stamp_o, 64'h0);
    for (int i = 0; i < NRD; i++) begin
      bus_read(RD_TAB[i][44], RD_TAB[i][43:32], rd);
      check($sformatf("R10/R1/R6/R11 table row %0d", i), 64'(rd), 64'(RD_TAB[i][31:0]));
    end
    // R5 mode register width
    bus_write(1'b0, 12'h000, 32'hFFFF_FFFE, 1'b0);
    bus_read(1'b0, 12'h000, rd);
    check("R5 mode readback", 64'(rd), 64'h1E);
    // R2 disabled counter ignores ticks
    ticks(5);
    check("R2 count held while disabled", stamp_o, 64'h0);
    bus_write(1'b0, 12'h000, 32'h1, 1'b0);
    bus_read(1'b0, 12'h000, rd);
    check("R5 mode enable only", 64'(rd), 64'h1);
    // R3 unit stepping
    ticks(7);
    check("R3 seven ticks", stamp_o, 64'h7);
    repeat (4) @(negedge clk);
    check("R3 no tick no change", stamp_o, 64'h7);
    bus_read(1'b0, 12'h008, rd);
    check("R7 ctrl lo read", 64'(rd), 64'h7);
    bus_read(1'b1, 12'h000, rd);
    check("R9 view lo read", 64'(rd), 64'h7);
    // R7 half writes
    bus_write(1'b0, 12'h00C, 32'h5, 1'b0);
    check("R7 hi write keeps lo", stamp_o, 64'h5_0000_0007);
    bus_write(1'b0, 12'h008, 32'hFFFF_FFFF, 1'b0);
    check("R7 lo write keeps hi", stamp_o, 64'h5_FFFF_FFFF);
    ticks(1);
    check("R3 carry into high half", stamp_o, 64'h6_0000_0000);
    check("R12 stamp tracks count", stamp_o, 64'h6_0000_0000);
    bus_read(1'b1, 12'h004, rd);
    check("R9 view hi read", 64'(rd), 64'h6);
    // R4 scaling
    bus_write(1'b0, 12'h000, 32'h0, 1'b0);
    bus_write(1'b0, 12'h00C, 32'h0, 1'b0);
    bus_write(1'b0, 12'h008, 32'h0, 1'b0);
    check("R7 write while disabled", stamp_o, 64'h0);
    bus_write(1'b0, 12'h0D0, 32'h0080_0000, 1'b0);
    bus_read(1'b0, 12'h010, rd);
    check("R6 scale alias", 64'(rd), 64'h0080_0000);
    bus_write(1'b0, 12'h000, 32'h5, 1'b0);
    ticks(3);
    check("R4 half scale three ticks", stamp_o, 64'h1);
    ticks(1);
    check("R4 half scale four ticks", stamp_o, 64'h2);
    bus_write(1'b0, 12'h010, 32'h0300_0000, 1'b0);
    ticks(2);
    check("R4 triple scale", stamp_o, 64'h8);
    bus_write(1'b0, 12'h0D0, 32'h0080_0000, 1'b0);
    ticks(1);
    check("R4 pending half", stamp_o, 64'h8);
    bus_write(1'b0, 12'h008, 32'h8, 1'b0);
    ticks(1);
    check("R7 fraction cleared by write", stamp_o, 64'h8);
    ticks(1);
    check("R4 after fraction clear", stamp_o, 64'h9);
    // R8 write and tick in the same cycle
    bus_write(1'b0, 12'h000, 32'h1, 1'b0);
    bus_write(1'b0, 12'h008, 32'h100, 1'b1);
    check("R8 write beats tick", stamp_o, 64'h100);
    ticks(1);
    check("R3 step after write", stamp_o, 64'h101);
    // R9 view window is read-only
    bus_write(1'b1, 12'h000, 32'hDEAD, 1'b0);
    bus_write(1'b1, 12'h004, 32'hBEEF, 1'b0);
    bus_read(1'b1, 12'h000, rd);
    check("R9 view write ignored (count)", 64'(rd), 64'h101);
    bus_read(1'b0, 12'h000, rd);
    check("R9 view write ignored (mode)", 64'(rd), 64'h1);
    // R6 read-only and dead offsets
    bus_write(1'b0, 12'h0D4, 32'h1234, 1'b0);
    bus_read(1'b0, 12'h0D4, rd);
    check("R6 dead offset reads zero", 64'(rd), 64'h0);
    bus_read(1'b0, 12'h010, rd);
    check("R6 dead offset no scale change", 64'(rd), 64'h0080_0000);
    bus_write(1'b0, 12'h01C, 32'hFFFF_FFFF, 1'b0);
    bus_read(1'b0, 12'h01C, rd);
    check("R6 ident read-only", 64'(rd), 64'h0002_0001);
    bus_write(1'b0, 12'h004, 32'hFFFF_FFFF, 1'b0);
    bus_read(1'b0, 12'h004, rd);
    check("R6 state reads zero", 64'(rd), 64'h0);
    // R11 held data and ignored low address bits
    repeat (3) @(negedge clk);
    check("R11 rdata held", 64'(bus_rdata_o), 64'h0);
    bus_read(1'b0, 12'h013, rd);
    check("R11 low address bits ignored", 64'(rd), 64'h0080_0000);
    bus_read(1'b0, 12'h200, rd);
    check("R11 unmapped zero", 64'(rd), 64'h0);
    // R1 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset clears count", stamp_o, 64'h0);
    bus_read(1'b0, 12'h010, rd);
    check("R1 reset restores scale", 64'(rd), 64'h0100_0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule